// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins an A-side bus and a B-side bus with two independent data paths, one from A to B and one from B to A. Each path owns a holding register, a capture strobe, a source select and an output enable. The output of a path either follows the opposite side's input combinationally (live mode) or presents the value held in that path's register (held mode). The register loads on a rising edge of its capture strobe, which is sampled against the block clock. A path with no rising strobe edge keeps its value.

The bus is split into lanes that are controlled independently. With the default parameters there are two 9-bit lanes. Driving all lane controls together makes the block behave as a single 18-bit transceiver. Tri-state pins are modelled as a data vector plus a per-bit enable vector. The enable of the A-to-B path is active high and the enable of the B-to-A path is active low. When the enclosing logic resolves the bus, enabling both paths at once gives a store-and-loopback path.

Top module: `bus_xcvr_top`

## Requirements
- R1: A synchronous active-high `rst` clears every holding register and every strobe-edge history to zero, so in held mode both outputs read 0 after reset.
- R2: The A-to-B register of a lane loads that lane's `a_in` bits at the clock edge where its `cap_ab` bit is first seen high after being low. Holding the strobe high, or holding it low, leaves the stored value unchanged.
- R3: With `sel_ab` of a lane at 0 (live), the lane's `b_out` bits equal its current `a_in` bits. With `sel_ab` at 1 (held), they equal the A-to-B register.
- R4: Each `b_en` bit of a lane is 1 when that lane's `oe_ab` is 1 and 0 when it is 0. All bits of a lane change together.
- R5: The B-to-A register of a lane loads that lane's `b_in` bits on a first-seen-high `cap_ba` bit, with the same hold behaviour as R2.
- R6: With `sel_ba` of a lane at 0, the lane's `a_out` bits equal `b_in`. With `sel_ba` at 1, they equal the B-to-A register.
- R7: `oe_ba_n` is active low: each `a_en` bit of a lane is 1 when that lane's `oe_ba_n` is 0 and 0 when it is 1.
- R8: Lane k (bits k*9 to k*9+8 by default) is governed only by bit k of each control input. Controls of one lane never change another lane's outputs or registers.
- R9: Clearing an output enable does not change the data output. It keeps showing its live or held value.
- R10: Capture does not depend on either output enable. A value driven onto B by the A-to-B path, and fed back to `b_in`, can be stored in the B-to-A register and later presented on `a_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | LANES*LANE_W | A-side bus input |
| b_in | input | LANES*LANE_W | B-side bus input |
| cap_ab | input | LANES | Per-lane capture strobe, A-to-B register |
| cap_ba | input | LANES | Per-lane capture strobe, B-to-A register |
| sel_ab | input | LANES | Per-lane B output source: 0 live, 1 held |
| sel_ba | input | LANES | Per-lane A output source: 0 live, 1 held |
| oe_ab | input | LANES | Per-lane B drive enable, active high |
| oe_ba_n | input | LANES | Per-lane A drive enable, active low |
| a_out | output | LANES*LANE_W | A-side data to be driven |
| a_en | output | LANES*LANE_W | A-side per-bit drive enable |
| b_out | output | LANES*LANE_W | B-side data to be driven |
| b_en | output | LANES*LANE_W | B-side per-bit drive enable |

## Verification
The bench builds the block with its defaults: two lanes of nine bits, which is an 18-bit bus. With two lanes, the vectors can give the halves opposite selects, enables and strobe states in the same cycle. A control that leaks across lanes then shows up as a wrong upper or lower half. The 9-bit lane boundary is not a nibble boundary, so the expected values also catch a slicing error at the split. The bench resolves the B bus itself, which lets it close the loop from the A-to-B output into the B-to-A register.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    typedef struct packed {
        logic cap;
        src_e src;
        logic oe;
    } lane_ctl_t;

    function automatic logic drive_on(input logic oe_pin, input bit active_low);
        return active_low ? ~oe_pin : oe_pin;
    endfunction

    function automatic lane_ctl_t make_ctl(input logic cap, input logic sel, input logic oe_pin);
        lane_ctl_t c;
        c.cap = cap;
        c.src = src_e'(sel);
        c.oe  = oe_pin;
        return c;
    endfunction

endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

    // R2: a rise is never reported two cycles in a row
    a_r2_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/xfer_path.sv
module xfer_path
    import bus_xcvr_pkg::*;
#(
    parameter int W      = 9,
    parameter bit OE_LOW = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_ctl_t      ctl,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout,
    output logic [W-1:0]   den
);
    logic         load;
    logic [W-1:0] held;

    strobe_rise u_rise (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctl.cap),
        .rise   (load)
    );

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (load) held <= din;
    end

    always_comb begin
        unique case (ctl.src)
            SRC_LIVE: dout = din;
            SRC_HELD: dout = held;
            default:  dout = din;
        endcase
    end

    assign den = {W{drive_on(ctl.oe, OE_LOW)}};

    // R1: reset leaves the register cleared
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (held == '0));

    // R2 / R5: load takes the input seen at the strobe edge
    a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (held == $past(din)));

    // R2 / R5: no strobe edge, no change
    a_r2_hold_value: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held));

    // R4 / R7: enables of a lane are all-or-nothing
    a_r4_lane_uniform: assert property (@(posedge clk) disable iff (rst)
        ($countones(den) == 0) || ($countones(den) == W));

    // R3 / R6: live mode follows the input
    a_r3_live_follow: assert property (@(posedge clk) disable iff (rst)
        (ctl.src == SRC_LIVE) |-> (dout == din));
endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
    import bus_xcvr_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int BUS_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [LANES-1:0] oe_ab,
    input  logic [LANES-1:0] oe_ba_n,
    output logic [BUS_W-1:0] a_out,
    output logic [BUS_W-1:0] a_en,
    output logic [BUS_W-1:0] b_out,
    output logic [BUS_W-1:0] b_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        lane_ctl_t ctl_ab;
        lane_ctl_t ctl_ba;

        assign ctl_ab = make_ctl(cap_ab[g], sel_ab[g], oe_ab[g]);
        assign ctl_ba = make_ctl(cap_ba[g], sel_ba[g], oe_ba_n[g]);

        xfer_path #(.W(LANE_W), .OE_LOW(1'b0)) u_ab (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl_ab),
            .din  (a_in[LO +: LANE_W]),
            .dout (b_out[LO +: LANE_W]),
            .den  (b_en[LO +: LANE_W])
        );

        xfer_path #(.W(LANE_W), .OE_LOW(1'b1)) u_ba (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl_ba),
            .din  (b_in[LO +: LANE_W]),
            .dout (a_out[LO +: LANE_W]),
            .den  (a_en[LO +: LANE_W])
        );

        // R7: active-low enable polarity seen at the ports
        a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
            oe_ba_n[g] |-> (a_en[LO +: LANE_W] == '0));

        // R9: in held mode, dropping the enable leaves the data steady
        a_r9_data_kept: assert property (@(posedge clk) disable iff (rst)
            ($fell(oe_ab[g]) && sel_ab[g] && $past(sel_ab[g]) && !$past(cap_ab[g]) && !cap_ab[g])
            |-> $stable(b_out[LO +: LANE_W]));
    end
endmodule

// File: tb/sim_bus_xcvr_top.sv
module sim_bus_xcvr_top;
    localparam int PERIOD = 10;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int BW = LW * NL;
    localparam logic [BW-1:0] ALL = '1;

    typedef struct packed {
        logic [BW-1:0] a;
        logic [BW-1:0] b;
        logic [NL-1:0] cab, cba, sab, sba, oab, oban;
        logic [BW-1:0] eb, ebe, ea, eae;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t TBL [NV] = '{
        '{18'h12345, 18'h0ABCD, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00,
          18'h12345, 18'h3FFFF, 18'h0ABCD, 18'h3FFFF},
        '{18'h12345, 18'h0ABCD, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11,
          18'h12345, 18'h00000, 18'h00000, 18'h00000},
        '{18'h00FFF, 18'h2A5A5, 2'b11, 2'b01, 2'b11, 2'b01, 2'b01, 2'b00,
          18'h12345, 18'h001FF, 18'h2A5A5, 18'h3FFFF},
        '{18'h00FFF, 18'h00000, 2'b10, 2'b01, 2'b01, 2'b01, 2'b10, 2'b10,
          18'h00F45, 18'h3FE00, 18'h001A5, 18'h001FF},
        '{18'h3F0F0, 18'h15555, 2'b01, 2'b00, 2'b11, 2'b00, 2'b11, 2'b01,
          18'h122F0, 18'h3FFFF, 18'h15555, 18'h3FE00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [BW-1:0] a_in, b_drv, b_in;
    logic [NL-1:0] cap_ab, cap_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
    logic loop_b = 1'b0;
    logic [BW-1:0] a_out, a_en, b_out, b_en;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    assign b_in = loop_b ? ((b_en & b_out) | (~b_en & b_drv)) : b_drv;

    bus_xcvr_top #(.LANE_W(LW), .LANES(NL)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_en(a_en), .b_out(b_out), .b_en(b_en)
    );

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        a_in = '0; b_drv = '0;
        cap_ab = '0; cap_ba = '0; sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
        step(); step();
        rst = 1'b0;
        @(negedge clk);
        // R1: held mode after reset reads zero
        chk("R1 reset b_out", b_out, '0);
        chk("R1 reset a_out", a_out, '0);
        chk("R4 reset b_en", b_en, ALL);
        chk("R7 reset a_en", a_en, ALL);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            a_in = TBL[i].a; b_drv = TBL[i].b;
            cap_ab = TBL[i].cab; cap_ba = TBL[i].cba;
            sel_ab = TBL[i].sab; sel_ba = TBL[i].sba;
            oe_ab = TBL[i].oab; oe_ba_n = TBL[i].oban;
            step();
            chk($sformatf("R2/R3/R8/R9 b_out vec %0d", i), b_out, TBL[i].eb);
            chk($sformatf("R4 b_en vec %0d", i), b_en, TBL[i].ebe);
            chk($sformatf("R5/R6/R8 a_out vec %0d", i), a_out, TBL[i].ea);
            chk($sformatf("R7 a_en vec %0d", i), a_en, TBL[i].eae);
        end

        // R1: reset in the middle of operation clears the stored values
        rst = 1'b1; cap_ab = '0; cap_ba = '0;
        sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
        step();
        rst = 1'b0;
        step();
        chk("R1 mid reset b_out", b_out, '0);
        chk("R1 mid reset a_out", a_out, '0);

        // R10: loop B output back into the B-to-A register
        a_in = 18'h1E0F3; b_drv = '0; loop_b = 1'b1;
        sel_ab = '0; oe_ab = '1; cap_ba = '1; sel_ba = '0; oe_ba_n = '1;
        step();
        a_in = '0; loop_b = 1'b0; oe_ab = '0; sel_ba = '1; oe_ba_n = '0;
        step();
        chk("R10 loopback a_out", a_out, 18'h1E0F3);
        chk("R10 loopback a_en", a_en, ALL);
        chk("R9 disabled b_out live", b_out, '0);

        // R2: strobe held high does not reload
        a_in = 18'h2AAAA; sel_ab = '1; cap_ab = '1;
        step();
        a_in = 18'h05555;
        step();
        chk("R2 held strobe no reload", b_out, 18'h2AAAA);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule